// File: doc/BRIEF.md
# Memory Sleep and Power-Up Access Sequencer

This block stands in front of a synchronous memory and decides, cycle by cycle, whether a read or write may be launched. After reset it holds the memory in a power-up state until the clock has run for a set number of cycles. Only then does it report the memory ready and let requests through.

A sleep request arrives asynchronously and is active high. It is resynchronised by a chain of flops and then moves the sequencer through three stages before it returns to normal service. The first is a short lockout in which no access may start. The second is sleep, in which the memory is forced deselected with its outputs parked. The third is a timed recovery after the request drops.

Any read or write presented during the lockout, sleep or recovery stages is refused and latches a violation flag that stays set until reset. A request during power-up is refused quietly. The surrounding logic uses `ready` to schedule traffic, uses `access_ok` as the per-cycle grant, and routes `force_desel` to the memory's select path.

Top module: `mem_sleep_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the block is in power-up: `ready`, `access_ok`, `force_desel` and `violation` are all 0.
- R2: `ready` rises after exactly PWRUP_CYCLES rising clock edges with `rst` low, and is 1 only in the normal state.
- R3: `sleep_req` passes through SYNC_STAGES flops (default 2). A rise held from just after edge k leaves normal operation at edge k+3, where `ready` falls.
- R4: The pre-sleep lockout lasts LOCKOUT_CYCLES edges (default 2). `ready` and `force_desel` stay 0 during it, and sleep is entered at the last of those edges.
- R5: In sleep, `force_desel` is 1. Sleep is left on the third edge after `sleep_req` falls, the same synchronizer delay as R3.
- R6: Recovery lasts RECOVER_CYCLES edges with `ready` and `force_desel` at 0. Normal operation then resumes.
- R7: `access_ok` is 1 exactly when `rd_req` or `wr_req` is high and the block is in the normal state.
- R8: A request during lockout, sleep or recovery gets `access_ok` 0. It sets `violation` at the next edge, and `violation` then stays 1 until reset.
- R9: A request during power-up gets `access_ok` 0 and does not set `violation`.
- R10: Once the lockout has started, it runs to sleep even if `sleep_req` has already fallen. Recovery then follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| rd_req | input | 1 | Read request for the current cycle |
| wr_req | input | 1 | Write request for the current cycle |
| ready | output | 1 | Memory in normal service |
| access_ok | output | 1 | Request granted this cycle |
| force_desel | output | 1 | Memory forced deselected, outputs parked (sleep) |
| violation | output | 1 | Sticky flag: a request arrived in a forbidden stage |

## Verification
Several properties are checked on every cycle:
- The violation flag never clears outside reset, and it only rises after a refused request.
- A grant never coincides with forced deselect.
- Sleep is entered only from the lockout and always left into recovery.
- `ready` only rises out of power-up or recovery.
- Each stage timer stays within its limit.

The exact cycle counts need the bench's scenarios, compared against a behavioural model on every clock. These are the synchronizer latency, the dwell lengths, the lockout running to completion after an early drop, and the quiet refusal in power-up.

// File: rtl/mem_sleep_pkg.sv
package mem_sleep_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP  = 3'd0,
        ST_NORMAL   = 3'd1,
        ST_PRESLEEP = 3'd2,
        ST_SLEEP    = 3'd3,
        ST_RECOVER  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic ready;
        logic grant;
        logic desel;
    } seq_flags_t;

    // Stages in which a request counts as a protocol violation
    function automatic logic is_forbidden(input seq_state_t st);
        return (st == ST_PRESLEEP) || (st == ST_SLEEP) || (st == ST_RECOVER);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/stage_timer.sv
module stage_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    assign last = limit - 1'b1;
    assign done = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (!done)  cnt_q <= cnt_q + 1'b1;
    end

    // The counter never runs past the final cycle of the current stage
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);
endmodule

// File: rtl/mem_sleep_seq.sv
module mem_sleep_seq
    import mem_sleep_pkg::*;
#(
    parameter int PWRUP_CYCLES   = 50000,
    parameter int LOCKOUT_CYCLES = 2,
    parameter int RECOVER_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic rd_req,
    input  logic wr_req,
    output logic ready,
    output logic access_ok,
    output logic force_desel,
    output logic violation
);
    localparam int TW = $clog2(max3(PWRUP_CYCLES, LOCKOUT_CYCLES, RECOVER_CYCLES) + 1) + 1;

    seq_state_t   state_q, state_d;
    seq_flags_t   flags;
    logic         sleep_s;
    logic         stage_done;
    logic         stage_clr;
    logic [TW-1:0] stage_limit;
    logic         any_req;
    logic         viol_q;

    assign any_req = rd_req | wr_req;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sleep_req),
        .q_sync  (sleep_s)
    );

    always_comb begin
        case (state_q)
            ST_POWERUP:  stage_limit = TW'(PWRUP_CYCLES);
            ST_PRESLEEP: stage_limit = TW'(LOCKOUT_CYCLES);
            ST_RECOVER:  stage_limit = TW'(RECOVER_CYCLES);
            default:     stage_limit = '0;
        endcase
    end

    assign stage_clr = (state_d != state_q);

    stage_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (stage_clr),
        .limit (stage_limit),
        .done  (stage_done)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_POWERUP:  if (stage_done) state_d = ST_NORMAL;
            ST_NORMAL:   if (sleep_s)    state_d = ST_PRESLEEP;
            ST_PRESLEEP: if (stage_done) state_d = ST_SLEEP;
            ST_SLEEP:    if (!sleep_s)   state_d = ST_RECOVER;
            ST_RECOVER:  if (stage_done) state_d = ST_NORMAL;
            default:                     state_d = ST_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POWERUP;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (any_req && is_forbidden(state_q)) viol_q <= 1'b1;
        end
    end

    always_comb begin
        flags.ready = (state_q == ST_NORMAL);
        flags.grant = flags.ready && any_req;
        flags.desel = (state_q == ST_SLEEP);
    end

    assign ready       = flags.ready;
    assign access_ok   = flags.grant;
    assign force_desel = flags.desel;
    assign violation   = viol_q;

    // Sticky violation flag
    assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);

    // Violation only rises after a refused request in a forbidden stage
    assert_viol_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(violation) |-> $past(any_req && is_forbidden(state_q)));

    // A grant never overlaps forced deselect
    assert_no_grant_asleep_R7: assert property (@(posedge clk) disable iff (rst)
        !(access_ok && force_desel));

    // Sleep is entered only from the lockout stage
    assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(force_desel) |-> $past(state_q) == ST_PRESLEEP);

    // Sleep is always left into recovery
    assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(force_desel) |-> state_q == ST_RECOVER);

    // Ready only comes out of power-up or recovery
    assert_ready_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(state_q) == ST_POWERUP || $past(state_q) == ST_RECOVER));
endmodule

// File: tb/mem_sleep_seq_test.sv
module mem_sleep_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P = 20;
    localparam int L = 2;
    localparam int R = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
    logic ready, access_ok, force_desel, violation;

    int checks = 0;
    int errors = 0;

    // Behavioural reference: 0 pwrup 1 normal 2 lockout 3 sleep 4 recover
    int m_st = 0, m_cnt = 0;
    bit m_s1 = 0, m_s2 = 0, m_viol = 0;

    mem_sleep_seq #(.PWRUP_CYCLES(P), .LOCKOUT_CYCLES(L), .RECOVER_CYCLES(R)) uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .rd_req(rd_req), .wr_req(wr_req),
        .ready(ready), .access_ok(access_ok), .force_desel(force_desel), .violation(violation)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_viol = 0;
        end else begin
            bit req;
            int prev;
            req = rd_req | wr_req;
            if (req && m_st >= 2) m_viol = 1;
            prev = m_st;
            case (m_st)
                0: if (m_cnt == P-1) m_st = 1;
                1: if (m_s2) m_st = 2;
                2: if (m_cnt == L-1) m_st = 3;
                3: if (!m_s2) m_st = 4;
                4: if (m_cnt == R-1) m_st = 1;
                default: m_st = 0;
            endcase
            m_cnt = (m_st != prev) ? 0 : m_cnt + 1;
            m_s2 = m_s1;
            m_s1 = sleep_req;
        end
    end

    always @(negedge clk) begin
        check("R2 ready", ready, m_st == 1);
        check("R7 access_ok", access_ok, (m_st == 1) && (rd_req | wr_req));
        check("R5 force_desel", force_desel, m_st == 3);
        check("R8 violation", violation, m_viol);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic look();
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        look();
        check("R1 ready", ready, 0);
        check("R1 force_desel", force_desel, 0);
        check("R1 violation", violation, 0);
        step(1); rst = 1'b0;
        look();
        check("R1 ready after release", ready, 0);
        // R9: request in power-up is refused without a violation
        rd_req = 1'b1;
        step(3);
        look();
        check("R9 access_ok", access_ok, 0);
        check("R9 violation", violation, 0);
        rd_req = 1'b0;
        step(P-4);
        look();
        check("R2 ready one edge early", ready, 0);
        step(1); look();
        check("R2 ready on time", ready, 1);
        // R7 grants
        step(1); wr_req = 1'b1; look();
        check("R7 write grant", access_ok, 1);
        step(1); wr_req = 1'b0; rd_req = 1'b1; look();
        check("R7 read grant", access_ok, 1);
        step(1); rd_req = 1'b0; look();
        check("R7 no request", access_ok, 0);
        // R3 synchronizer latency, R4 lockout
        sleep_req = 1'b1;
        step(2); look();
        check("R3 still ready", ready, 1);
        step(1); look();
        check("R3 left normal", ready, 0);
        step(L-1); look();
        check("R4 lockout no desel", force_desel, 0);
        step(1); look();
        check("R4 sleep entered", force_desel, 1);
        step(5); look();
        check("R5 stays asleep", force_desel, 1);
        sleep_req = 1'b0;
        step(2); look();
        check("R5 still asleep", force_desel, 1);
        step(1); look();
        check("R5 sleep left", force_desel, 0);
        check("R6 recover not ready", ready, 0);
        step(R-1); look();
        check("R6 recover still blocked", ready, 0);
        step(1); look();
        check("R6 ready again", ready, 1);
        check("R8 clean so far", violation, 0);
        // R10: request drops during lockout
        sleep_req = 1'b1;
        step(3); sleep_req = 1'b0; look();
        check("R10 in lockout", ready, 0);
        step(L); look();
        check("R10 sleep reached", force_desel, 1);
        step(R + 2); look();
        check("R10 back to ready", ready, 1);
        // R8: request in lockout
        sleep_req = 1'b1;
        step(4); wr_req = 1'b1; look();
        check("R8 refused", access_ok, 0);
        step(1); wr_req = 1'b0; look();
        check("R8 flag set", violation, 1);
        step(3); sleep_req = 1'b0;
        step(R + 4); look();
        check("R8 sticky", violation, 1);
        check("R8 normal resumed", ready, 1);
        rst = 1'b1;
        step(1); look();
        check("R1 reset clears violation", violation, 0);
        check("R1 reset clears ready", ready, 0);
        rst = 1'b0;
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule